// File: doc/BRIEF.md
# Serial Register Slave with Time Snapshot

This block is the two-wire serial (I2C) slave front end of a real-time clock. It answers one fixed 7-bit device address and exposes a 17-entry byte register space, indices 00h to 10h. A register pointer selects the entry for the next access. It is loaded by the first byte of a write. It moves forward by one after every byte stored or sent, and from 10h it returns to 00h. The timekeeping logic outside this block owns the running time value, indices 00h to 06h. It presents that value on a parallel input and takes register writes from a one-cycle write strobe. The configuration entries, indices 07h to 10h, are held inside this block.

Reads of the time entries come from a shadow copy, not from the live value. The shadow is refreshed at every START condition, at every STOP condition, and whenever the pointer returns to 00h. A multi-byte read therefore returns one consistent instant even while the clock keeps counting. The slave drives SDA only by pulling it low, through `sda_oe`. It samples data on SCL rising edges and changes its own SDA output only while SCL is low. It stops driving after a NACK from the master. If SCL stays low longer than a programmable number of clock cycles, it drops the transfer and waits for a new START.

Top module: `i2c_snap_regslave`

## Requirements
- R1: A device address byte whose upper seven bits are 1101000 is acknowledged (SDA pulled low in the ninth clock). Any other address is not acknowledged, and the slave ignores all further bytes until the next START or STOP.
- R2: With R/W bit 0, the byte after the address loads the pointer. Each further byte is acknowledged and appears on the write strobe as a single-cycle `wr_en` with `wr_addr` equal to the pointer and `wr_data` equal to the byte, raised on the SCL rising edge of its acknowledge clock. The pointer then increments.
- R3: With R/W bit 1, bytes are shifted out MSB first, starting at the current pointer. This is the last value loaded, or advanced, by an earlier access. The pointer increments after each byte. SDA changes only while SCL is low.
- R4: The pointer advances from 10h to 00h, for reads and writes alike. A pointer byte above 10h loads 00h.
- R5: Reads of indices 00h to 06h return the time value captured at the most recent START, STOP or pointer wrap to 00h, where byte i of `time_live` is bits 8i+7 to 8i. Later changes of `time_live` are not visible until the next such event.
- R6: After the master answers a read byte with NACK (SDA high in the ninth clock), the slave leaves SDA released on every following clock until the next START.
- R7: If SCL stays low for `TIMEOUT_CYC` clock cycles, the slave releases SDA and ignores bus traffic, sending no acknowledge and making no write, until the next START.
- R8: `trickle_en` is 1 exactly when the last byte written to index 10h has upper nibble 1010. It changes only on a write to 10h.
- R9: After reset `sda_oe`, `wr_en` and `trickle_en` are 0, the pointer is 00h, and every configuration entry (07h to 10h) reads 00h.
- R10: Bytes written to indices 07h to 10h read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| time_live | input | 56 | Running time, byte i for index i (00h to 06h) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register index of the write |
| wr_data | output | 8 | Byte to write |
| trickle_en | output | 1 | Charger enable decoded from index 10h |

## Verification
Directed transfers cover the cases that separate correct from nearly correct behaviour. A foreign address is followed by data bytes that must not produce writes. A write that sets the pointer is followed by a repeated-START read, which tells pointer loading apart from pointer advance. Reads that start at 0Fh cross the wrap, and `time_live` is changed after START but before the wrap, which tells a wrap-triggered capture apart from one taken only on START. A read with `time_live` changed in the middle shows whether bytes come from the shadow or from the live value. SCL is held low in the middle of a byte to show that the timeout drops the transfer. Random bursts of writes and reads over the configuration entries, with random start pointers and lengths, are compared against a bench model of the register space. These bursts mix in writes to the charger entry with random upper nibbles.

// File: rtl/i2c_snap_pkg.sv
package i2c_snap_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_PTR,
    ST_PTRACK,
    ST_WDAT,
    ST_WDACK,
    ST_RDAT,
    ST_MACK
  } slv_state_t;
endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  // SDA edges with SCL high on both sides of the edge are bus conditions
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/rs_low_timeout.sv
module rs_low_timeout #(
  parameter int LIMIT = 7_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || scl_lvl) low_cnt <= '0;
    else if (low_cnt != CW'(LIMIT)) low_cnt <= low_cnt + 1'b1;
  end

  assign expired = ~scl_lvl & (low_cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/rs_reg_bank.sv
module rs_reg_bank #(
  parameter int NUM_REGS = 17,
  parameter int NUM_TIME = 7,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter logic [3:0] CHG_KEY = 4'b1010
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   snap,
  input  logic [NUM_TIME*DW-1:0] time_live,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic                   trickle_en
);
  localparam int NUM_CFG = NUM_REGS - NUM_TIME;
  localparam int CFW     = $clog2(NUM_CFG);
  localparam int TW      = $clog2(NUM_TIME);

  logic [DW-1:0] shadow [NUM_TIME];
  logic [DW-1:0] cfg    [NUM_CFG];
  logic [AW-1:0] cfg_wi, cfg_ri;

  assign cfg_wi = wr_addr - AW'(NUM_TIME);
  assign cfg_ri = rd_addr - AW'(NUM_TIME);

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst) shadow[i] <= '0;
      else if (snap) shadow[i] <= time_live[i*DW +: DW];
    end
  end

  for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) cfg[j] <= '0;
      else if (wr_en && wr_addr >= AW'(NUM_TIME) && cfg_wi[CFW-1:0] == CFW'(j))
        cfg[j] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trickle_en <= 1'b0;
    else if (wr_en && wr_addr == AW'(NUM_REGS - 1))
      trickle_en <= (wr_data[DW-1:DW-4] == CHG_KEY);
  end

  always_comb begin
    if (rd_addr < AW'(NUM_TIME))      rd_data = shadow[rd_addr[TW-1:0]];
    else if (rd_addr < AW'(NUM_REGS)) rd_data = cfg[cfg_ri[CFW-1:0]];
    else                              rd_data = '0;
  end
endmodule

// File: rtl/i2c_snap_regslave.sv
module i2c_snap_regslave
  import i2c_snap_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101000,
  parameter int         NUM_REGS    = 17,
  parameter int         NUM_TIME    = 7,
  parameter int         DW          = 8,
  parameter int         AW          = 5,
  parameter int         SYNC_STAGES = 2,
  parameter int         TIMEOUT_CYC = 7_000_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [NUM_TIME*DW-1:0] time_live,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [DW-1:0]          wr_data,
  output logic                   trickle_en
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);
  localparam int BCW = $clog2(DW + 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev, tmo;
  slv_state_t    state;
  logic [BCW-1:0] bcnt;
  logic [DW-1:0] sh, tx, rd_byte;
  logic [AW-1:0] ptr, ptr_next;
  logic          rw, nak, bus_ev, inc_ev, wrap_ev, snap;

  rs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  rs_low_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .expired(tmo)
  );

  // pointer advance points: ack clock of a written byte, end of a sent byte
  assign bus_ev   = tmo | start_ev | stop_ev;
  assign inc_ev   = ~bus_ev & (((state == ST_WDACK) & scl_rise) |
                    ((state == ST_RDAT) & scl_fall & (bcnt == BCW'(DW))));
  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign wrap_ev  = inc_ev & (ptr == LAST);
  assign snap     = start_ev | stop_ev | wrap_ev;

  rs_reg_bank #(.NUM_REGS(NUM_REGS), .NUM_TIME(NUM_TIME), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .snap(snap), .time_live(time_live),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_byte), .trickle_en(trickle_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      nak     <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (inc_ev) ptr <= ptr_next;
      if (tmo || stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_DEVADR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_DEVADR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              sh   <= {sh[DW-2:0], sda_lvl};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == BCW'(DW)) begin
              bcnt <= '0;
              if (state == ST_DEVADR) begin
                if (sh[DW-1:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEVACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr    <= (sh < DW'(NUM_REGS)) ? sh[AW-1:0] : '0;
                sda_oe <= 1'b1;
                state  <= ST_PTRACK;
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WDACK;
              end
            end
          end
          ST_DEVACK: if (scl_fall) begin
            bcnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[DW-1];
              state  <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_PTRACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDAT;
          end
          ST_WDACK: begin
            if (scl_rise) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= sh;
            end else if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == BCW'(DW)) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                tx     <= {tx[DW-2:0], 1'b0};
                sda_oe <= ~tx[DW-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nak <= sda_lvl;
            end else if (scl_fall) begin
              bcnt <= '0;
              if (nak) begin
                state <= ST_IDLE;
              end else begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[DW-1];
                state  <= ST_RDAT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_snap_regslave_chk.sv
module i2c_snap_regslave_chk #(
  parameter int NUM_REGS = 17,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          trickle_en
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !wr_en && !trickle_en)); // R9

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R2

  AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= LAST)); // R4

  AST_CHG_DECODE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LAST) |=> (trickle_en == ($past(wr_data[DW-1:DW-4]) == 4'b1010))); // R8

  AST_CHG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == LAST) |=> $stable(trickle_en)); // R8

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R3
endmodule

bind i2c_snap_regslave i2c_snap_regslave_chk #(
  .NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .trickle_en(trickle_en)
);

// File: tb/tb_i2c_snap_regslave.sv
`timescale 1ns/1ps
module tb_i2c_snap_regslave;
  localparam int Q   = 6;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wr_en, trickle_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [55:0] time_live = '0;
  wire sda_bus = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_snap_regslave #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .time_live(time_live), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trickle_en(trickle_en)
  );

  int total = 0, fails = 0, wn = 0;
  bit done = 1'b0;
  logic [4:0] wa [256];
  logic [7:0] wd [256];
  logic [7:0] model [17];
  logic [7:0] rbuf [8];

  always @(negedge clk) if (!rst && wr_en && wn < 256) begin
    wa[wn] = wr_addr; wd[wn] = wr_data; wn = wn + 1;
  end

  function automatic logic [7:0] tbyte(input logic [55:0] t, input int i);
    return t[i*8 +: 8];
  endfunction
  function automatic logic [7:0] exp_byte(input int a, input logic [55:0] t);
    return (a < 7) ? tbyte(t, a) : model[a];
  endfunction
  function automatic logic exp_chg();
    return model[16][7:4] == 4'b1010;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask
  task automatic bstart(); m_sda = 1; wt(Q); m_scl = 1; wt(2*Q); m_sda = 0; wt(2*Q); m_scl = 0; wt(Q); endtask
  task automatic bstop();  m_sda = 0; wt(Q); m_scl = 1; wt(2*Q); m_sda = 1; wt(2*Q); endtask
  task automatic bitw(input logic b); m_sda = b; wt(Q); m_scl = 1; wt(2*Q); m_scl = 0; wt(Q); endtask
  task automatic bitr(output logic v);
    m_sda = 1; wt(Q); m_scl = 1; wt(Q); @(negedge clk) v = sda_bus; wt(Q); m_scl = 0; wt(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bitw(b[i]);
    bitr(v); acked = ~v;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin bitr(v); d[i] = v; end
    bitw(~ack);
  endtask

  task automatic wr_seq(input int p, input int n, input logic [7:0] d0, d1, d2);
    logic a; logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bstart(); send_byte(8'hD0, a); send_byte(8'(p), a);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      if ((p + i) % 17 >= 7) model[(p + i) % 17] = d[i];
    end
    bstop();
  endtask
  task automatic rd_seq(input int p, input int n);
    logic a;
    bstart(); send_byte(8'hD0, a); send_byte(8'(p), a);
    bstart(); send_byte(8'hD1, a);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic a, v; logic [55:0] ta, tb2; int w0;
    for (int i = 0; i < 17; i++) model[i] = 8'h00;
    void'($urandom(1234));
    wt(5); rst = 0; wt(2);
    @(negedge clk);
    chk(sda_oe == 0 && wr_en == 0 && trickle_en == 0, "R9 reset outputs", {sda_oe, wr_en, trickle_en}, 0);

    // R9: reset pointer is 00h and configuration reads 00h
    time_live = 56'h06_05_04_03_02_01_00;
    bstart(); send_byte(8'hD1, a); recv_byte(rbuf[0], 0); bstop();
    chk(rbuf[0] == 8'h00, "R9 pointer after reset", rbuf[0], 8'h00);
    rd_seq(7, 3);
    chk(rbuf[0] == 0 && rbuf[1] == 0 && rbuf[2] == 0, "R9 cfg reset", {rbuf[0], rbuf[1], rbuf[2]}, 0);

    // R1 foreign address
    w0 = wn;
    bstart(); send_byte(8'hA0, a);
    chk(!a, "R1 foreign address not acked", a, 0);
    send_byte(8'h08, a); chk(!a, "R1 ignored byte not acked", a, 0);
    send_byte(8'h55, a); bstop();
    chk(wn == w0, "R1 no write after foreign address", wn - w0, 0);

    // R1/R2 write
    w0 = wn;
    bstart(); send_byte(8'hD0, a);
    chk(a, "R1 own address acked", a, 1);
    send_byte(8'h07, a); send_byte(8'h11, a); send_byte(8'h22, a); bstop();
    model[7] = 8'h11; model[8] = 8'h22;
    chk(wn == w0 + 2, "R2 write count", wn - w0, 2);
    chk(wa[w0] == 7 && wd[w0] == 8'h11, "R2 first write", {wa[w0], wd[w0]}, {5'd7, 8'h11});
    chk(wa[w0+1] == 8 && wd[w0+1] == 8'h22, "R2 pointer increments", {wa[w0+1], wd[w0+1]}, {5'd8, 8'h22});

    // R3/R10 read back, R6 NACK release
    bstart(); send_byte(8'hD0, a); send_byte(8'h07, a);
    bstart(); send_byte(8'hD1, a);
    recv_byte(rbuf[0], 1); recv_byte(rbuf[1], 0);
    bitr(v);
    chk(v == 1, "R6 SDA released after NACK", v, 1);
    bitr(v);
    chk(v == 1, "R6 SDA still released", v, 1);
    bstop();
    chk(rbuf[0] == 8'h11 && rbuf[1] == 8'h22, "R10 readback", {rbuf[0], rbuf[1]}, 16'h1122);
    bstart(); send_byte(8'hD1, a); recv_byte(rbuf[0], 0); bstop();
    chk(rbuf[0] == model[9], "R3 read from current pointer", rbuf[0], model[9]);

    // R8 charger decode
    wr_seq(16, 1, 8'hA5, 0, 0); @(negedge clk);
    chk(trickle_en == 1, "R8 key 1010", trickle_en, 1);
    wr_seq(16, 1, 8'h5A, 0, 0); @(negedge clk);
    chk(trickle_en == 0, "R8 swapped nibble", trickle_en, 0);
    wr_seq(16, 1, 8'hAF, 0, 0); @(negedge clk);
    chk(trickle_en == 1, "R8 lower nibble free", trickle_en, 1);
    wr_seq(9, 1, 8'h00, 0, 0); @(negedge clk);
    chk(trickle_en == 1, "R8 other write no effect", trickle_en, 1);
    wr_seq(16, 1, 8'hB0, 0, 0); @(negedge clk);
    chk(trickle_en == 0, "R8 near key", trickle_en, 0);

    // R4 write wrap
    w0 = wn;
    wr_seq(16, 2, 8'hA9, 8'h3C, 0);
    chk(wn == w0 + 2 && wa[w0+1] == 0 && wd[w0+1] == 8'h3C, "R4 write wraps to 00h", wa[w0+1], 0);
    w0 = wn;
    wr_seq(8'h33, 1, 8'h77, 0, 0);
    chk(wa[w0] == 0, "R4 oversize pointer loads 00h", wa[w0], 0);

    // R5 snapshot held during read
    ta = 56'h25_12_31_07_23_59_58; tb2 = 56'h26_01_01_01_00_00_00;
    time_live = ta;
    bstart(); send_byte(8'hD0, a); send_byte(8'h00, a);
    bstart(); send_byte(8'hD1, a);
    recv_byte(rbuf[0], 1);
    time_live = tb2;
    for (int i = 1; i < 7; i++) recv_byte(rbuf[i], i != 6);
    bstop();
    for (int i = 0; i < 7; i++)
      chk(rbuf[i] == tbyte(ta, i), "R5 shadow stable during read", rbuf[i], tbyte(ta, i));
    rd_seq(0, 2);
    chk(rbuf[0] == tbyte(tb2, 0) && rbuf[1] == tbyte(tb2, 1), "R5 new snapshot on next START",
        {rbuf[0], rbuf[1]}, {tbyte(tb2, 0), tbyte(tb2, 1)});

    // R4/R5 wrap during read captures a fresh snapshot
    time_live = ta;
    bstart(); send_byte(8'hD0, a); send_byte(8'h0F, a);
    bstart(); send_byte(8'hD1, a);
    time_live = tb2 ^ 56'h00_00_00_00_00_00_5A;
    recv_byte(rbuf[0], 1); recv_byte(rbuf[1], 1); recv_byte(rbuf[2], 0);
    bstop();
    chk(rbuf[0] == model[15] && rbuf[1] == model[16], "R4 read 0Fh and 10h",
        {rbuf[0], rbuf[1]}, {model[15], model[16]});
    chk(rbuf[2] == 8'h5A, "R4 R5 wrap to 00h refreshes shadow", rbuf[2], 8'h5A);

    // R7 SCL low timeout
    w0 = wn;
    bstart(); send_byte(8'hD0, a); send_byte(8'h08, a);
    bitw(0); bitw(1); bitw(1);
    m_scl = 0; wt(TMO + 60);
    @(negedge clk);
    chk(sda_oe == 0, "R7 SDA released on timeout", sda_oe, 0);
    for (int i = 0; i < 5; i++) bitw(1'b0);
    bitr(v);
    chk(v == 1, "R7 no ack after timeout", v, 1);
    send_byte(8'h44, a);
    chk(!a, "R7 traffic ignored after timeout", a, 0);
    chk(wn == w0, "R7 no write after timeout", wn - w0, 0);
    bstop();
    wr_seq(10, 1, 8'h5E, 0, 0);
    rd_seq(10, 1);
    chk(rbuf[0] == 8'h5E, "R7 recovers at next START", rbuf[0], 8'h5E);

    // random bursts (R2 R3 R10 R8)
    time_live = 56'h11_22_33_44_55_66_77;
    for (int it = 0; it < 14; it++) begin
      int p, n, rp, rn;
      logic [7:0] d0, d1, d2;
      p = 7 + int'($urandom % 8); n = 1 + int'($urandom % 3);
      d0 = 8'($urandom); d1 = 8'($urandom); d2 = 8'($urandom);
      if ($urandom % 2 == 0) d1 = {4'b1010, d1[3:0]};
      wr_seq(p, n, d0, d1, d2);
      @(negedge clk);
      chk(trickle_en == exp_chg(), "R8 random charger state", trickle_en, exp_chg());
      rp = int'($urandom % 17); rn = 1 + int'($urandom % 4);
      rd_seq(rp, rn);
      for (int i = 0; i < rn; i++)
        chk(rbuf[i] == exp_byte((rp + i) % 17, time_live), "R3 R10 random read",
            rbuf[i], exp_byte((rp + i) % 17, time_live));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule